// File: doc/BRIEF.md
# UART Interrupt Status, Mask and Counter-Timer Section

This block is the shared control section of a two-channel UART. It sits on a byte-wide register bus. It gathers the per-channel transmitter, receiver and break status into one 8-bit interrupt status register and combines that register with an 8-bit mask to drive a single interrupt line. It also contains a 16-bit counter/timer and an input-pin change detector.

Channel status arrives in two forms. The transmitter-ready and receiver-ready conditions are level inputs. Break changes are set and clear pulses. The timer preset is loaded one byte at a time. A bus read of one strobe address starts a countdown of `preset × multiplier` tick strobes, and a read of a second strobe address cancels it. When the countdown expires it raises the counter-ready status bit. The input-pin register reports the current pin levels in its low nibble and sticky change flags in its high nibble. Reading that register clears the change flags.

The countdown is a two-state machine. Its states are `TMR_IDLE` and `TMR_COUNT`, with these transitions:
- **start**: `TMR_IDLE` or `TMR_COUNT` goes to `TMR_COUNT` on a read of offset 14. A start from `TMR_COUNT` is a restart.
- **stop**: `TMR_COUNT` goes to `TMR_IDLE` on a read of offset 15.
- **expire**: `TMR_COUNT` goes to `TMR_IDLE` when the count runs out.

Top module: `uart_irq_timer`

## Requirements
- R1: `irq` is high exactly when the bitwise AND of the mask register and the status register is nonzero. A bus write to offset 5 loads the mask, and `irq` reflects the new mask in the cycle after the write.
- R2: A bus read of offset 5 returns the status register, never the mask. The status bit layout is: bit0 transmitter ready A, bit1 receiver ready A, bit2 break change A, bit3 counter ready, bit4 transmitter ready B, bit5 receiver ready B, bit6 break change B, bit7 input change.
- R3: Status bits 0, 1, 4 and 5 follow the `tx_rdy`/`rx_rdy` inputs (index 0 = channel A, index 1 = channel B), one clock later.
- R4: A `brk_set` pulse sets that channel's break bit, which then stays set until a `brk_clr` pulse for the same channel. When both pulses arrive in the same cycle, the bit is set.
- R5: A write to offset 6 replaces the upper preset byte and a write to offset 7 replaces the lower byte; neither write touches the other byte. Reads of offsets 6 and 7 return those bytes.
- R6: A read of offset 14 returns 0x00, clears status bit3 and starts a countdown of N = preset × (`tick_mult` + 1) `tick` pulses. Bit3 sets on the clock edge of the N-th tick. If N is 0, bit3 sets on the second edge after the start read.
- R7: A read of offset 15 returns 0x00, clears status bit3 and cancels any countdown, so bit3 stays clear afterwards.
- R8: A read of offset 14 while a countdown runs restarts it from the full count.
- R9: A read of offset 4 returns {change flags[3:0], pin levels[3:0]}. The pin levels are `in_pins` registered once. A change flag sets when a pin differs from its registered level. The read clears the flags, but a change detected in the same cycle as the read keeps its flag.
- R10: Status bit7 is high whenever any input change flag is set.
- R11: After reset, the status, mask, preset, change flags and pin levels are zero, no countdown runs, and `irq` is low.
- R12: Writes to offsets 4, 14 and 15 have no effect; in particular, a write to offset 14 starts no countdown. Reads of unused offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the access cycle |
| tick | input | 1 | One-cycle timer tick strobe |
| tick_mult | input | MULT_W | Tick multiplier minus one |
| tx_rdy | input | 2 | Transmitter-ready levels, channels B:A |
| rx_rdy | input | 2 | Receiver-ready levels, channels B:A |
| brk_set | input | 2 | Break-change set pulses, channels B:A |
| brk_clr | input | 2 | Break-change clear pulses, channels B:A |
| in_pins | input | PIN_N | Monitored input pins |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches several rules on every cycle:
- both strobe addresses read as zero;
- a start read leaves the timer running with counter-ready clear;
- a stop read leaves it idle;
- a break pulse leaves its bit set;
- an upper-byte preset write changes only that byte;
- a change-register read with unchanged pins empties the flags;
- a zero-mask write silences `irq`;
- a write to the start address never starts the timer.

Only the bench scenarios can show the exact expiry tick for a given preset and multiplier, the restart and cancel outcomes, the zero-count case, a pin change racing a clearing read, and the full status layout as seen through the bus.

// File: rtl/uart_irq_timer_pkg.sv
package uart_irq_timer_pkg;
    localparam int PRESET_W = 16;
    localparam int REG_W    = 8;
    localparam int ADDR_W   = 4;

    localparam logic [ADDR_W-1:0] OFS_PINCHG = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_PRE_HI = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_PRE_LO = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_START  = 4'd14;
    localparam logic [ADDR_W-1:0] OFS_STOP   = 4'd15;

    typedef enum logic {
        TMR_IDLE  = 1'b0,
        TMR_COUNT = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/uit_timer.sv
module uit_timer
    import uart_irq_timer_pkg::*;
#(
    parameter int MULT_MAX = 4,
    localparam int MULT_W  = (MULT_MAX > 1) ? $clog2(MULT_MAX) : 1,
    localparam int CNT_W   = PRESET_W + MULT_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic [REG_W-1:0]    wdata,
    input  logic                start,
    input  logic                stop,
    input  logic                tick,
    input  logic [MULT_W-1:0]   mult,
    output logic [PRESET_W-1:0] preset,
    output logic                expire,
    output logic                running
);
    tmr_state_e         state_q, state_d;
    logic [CNT_W-1:0]   remain_q;
    logic [CNT_W-1:0]   load_val;
    logic [CNT_W-1:0]   factor;

    assign factor   = CNT_W'(mult) + CNT_W'(1);
    assign load_val = CNT_W'(preset) * factor;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset <= '0;
        end else begin
            if (wr_hi) preset[PRESET_W-1:REG_W] <= wdata;
            if (wr_lo) preset[REG_W-1:0]        <= wdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE:  if (start) state_d = TMR_COUNT;
            TMR_COUNT: begin
                if (stop)        state_d = TMR_IDLE;
                else if (start)  state_d = TMR_COUNT;
                else if (expire) state_d = TMR_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        running = (state_q == TMR_COUNT);
        expire  = running && !start && !stop &&
                  ((remain_q == '0) || (tick && remain_q == CNT_W'(1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start) begin
            remain_q <= load_val;
        end else if (running && tick && remain_q != '0) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/uit_inport.sv
module uit_inport #(
    parameter int PIN_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_N-1:0] pins,
    input  logic             clr,
    output logic [PIN_N-1:0] levels,
    output logic [PIN_N-1:0] flags,
    output logic             any_change
);
    for (genvar p = 0; p < PIN_N; p++) begin : g_pin
        logic lvl_q, flg_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_q <= 1'b0;
                flg_q <= 1'b0;
            end else begin
                lvl_q <= pins[p];
                flg_q <= (pins[p] != lvl_q) | (flg_q & ~clr);
            end
        end
        assign levels[p] = lvl_q;
        assign flags[p]  = flg_q;
    end

    assign any_change = |flags;
endmodule

// File: rtl/uit_status.sv
module uit_status
    import uart_irq_timer_pkg::*;
#(
    parameter int CH_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_N-1:0]  tx_rdy,
    input  logic [CH_N-1:0]  rx_rdy,
    input  logic [CH_N-1:0]  brk_set,
    input  logic [CH_N-1:0]  brk_clr,
    input  logic             ct_expire,
    input  logic             ct_clear,
    input  logic             chg_any,
    input  logic             mask_we,
    input  logic [REG_W-1:0] mask_wdata,
    output logic [REG_W-1:0] status,
    output logic             irq
);
    localparam int CH_STRIDE = REG_W / CH_N;

    logic [REG_W-1:0] mask_q;
    logic             ready_q;

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        logic tx_q, rx_q, brk_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tx_q  <= 1'b0;
                rx_q  <= 1'b0;
                brk_q <= 1'b0;
            end else begin
                tx_q  <= tx_rdy[c];
                rx_q  <= rx_rdy[c];
                brk_q <= brk_set[c] | (brk_q & ~brk_clr[c]);
            end
        end
        assign status[c*CH_STRIDE + 0] = tx_q;
        assign status[c*CH_STRIDE + 1] = rx_q;
        assign status[c*CH_STRIDE + 2] = brk_q;
    end

    assign status[3] = ready_q;
    assign status[7] = chg_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            mask_q  <= '0;
        end else begin
            if (ct_clear)       ready_q <= 1'b0;
            else if (ct_expire) ready_q <= 1'b1;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    assign irq = |(status & mask_q);
endmodule

// File: rtl/uart_irq_timer.sv
module uart_irq_timer
    import uart_irq_timer_pkg::*;
#(
    parameter int MULT_MAX = 4,
    parameter int PIN_N    = 4,
    localparam int MULT_W  = (MULT_MAX > 1) ? $clog2(MULT_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              tick,
    input  logic [MULT_W-1:0] tick_mult,
    input  logic [1:0]        tx_rdy,
    input  logic [1:0]        rx_rdy,
    input  logic [1:0]        brk_set,
    input  logic [1:0]        brk_clr,
    input  logic [PIN_N-1:0]  in_pins,
    output logic              irq
);
    logic                rd_en, wr_en;
    logic                tmr_start, tmr_stop, tmr_expire, tmr_running;
    logic [PRESET_W-1:0] preset;
    logic [PIN_N-1:0]    pin_lvl, pin_flags;
    logic                pin_any;
    logic [REG_W-1:0]    status;

    assign rd_en     = bus_sel & ~bus_wr;
    assign wr_en     = bus_sel &  bus_wr;
    assign tmr_start = rd_en && bus_addr == OFS_START;
    assign tmr_stop  = rd_en && bus_addr == OFS_STOP;

    uit_timer #(.MULT_MAX(MULT_MAX)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (wr_en && bus_addr == OFS_PRE_HI),
        .wr_lo   (wr_en && bus_addr == OFS_PRE_LO),
        .wdata   (bus_wdata),
        .start   (tmr_start),
        .stop    (tmr_stop),
        .tick    (tick),
        .mult    (tick_mult),
        .preset  (preset),
        .expire  (tmr_expire),
        .running (tmr_running)
    );

    uit_inport #(.PIN_N(PIN_N)) u_inport (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins       (in_pins),
        .clr        (rd_en && bus_addr == OFS_PINCHG),
        .levels     (pin_lvl),
        .flags      (pin_flags),
        .any_change (pin_any)
    );

    uit_status #(.CH_N(2)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_rdy     (tx_rdy),
        .rx_rdy     (rx_rdy),
        .brk_set    (brk_set),
        .brk_clr    (brk_clr),
        .ct_expire  (tmr_expire),
        .ct_clear   (tmr_start | tmr_stop),
        .chg_any    (pin_any),
        .mask_we    (wr_en && bus_addr == OFS_STATUS),
        .mask_wdata (bus_wdata),
        .status     (status),
        .irq        (irq)
    );

    always_comb begin
        case (bus_addr)
            OFS_PINCHG: bus_rdata = REG_W'({pin_flags, pin_lvl});
            OFS_STATUS: bus_rdata = status;
            OFS_PRE_HI: bus_rdata = preset[PRESET_W-1:REG_W];
            OFS_PRE_LO: bus_rdata = preset[REG_W-1:0];
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_irq_timer_chk.sv
module uart_irq_timer_chk
    import uart_irq_timer_pkg::*;
#(
    parameter int PIN_N = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [REG_W-1:0]    bus_wdata,
    input logic [REG_W-1:0]    bus_rdata,
    input logic [1:0]          brk_set,
    input logic [PIN_N-1:0]    in_pins,
    input logic                irq,
    input logic [REG_W-1:0]    status,
    input logic [PRESET_W-1:0] preset,
    input logic                tmr_running,
    input logic [PIN_N-1:0]    pin_lvl,
    input logic [PIN_N-1:0]    pin_flags
);
    logic rd, wr;
    assign rd = bus_sel && !bus_wr;
    assign wr = bus_sel && bus_wr;

    assert_mask_zero_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_STATUS && bus_wdata == '0) |=> !irq);

    assert_strobe_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (bus_addr == OFS_START || bus_addr == OFS_STOP)) |-> bus_rdata == '0);

    assert_start_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == OFS_START) |=> (tmr_running && !status[3]));

    assert_stop_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == OFS_STOP) |=> (!tmr_running && !status[3]));

    assert_break_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_set[0] |=> status[2]);

    assert_preset_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_PRE_HI) |=>
            (preset[PRESET_W-1:REG_W] == $past(bus_wdata) && $stable(preset[REG_W-1:0])));

    assert_read_clears_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == OFS_PINCHG && in_pins == pin_lvl) |=> pin_flags == '0);

    assert_write_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_START && !tmr_running) |=> !tmr_running);
endmodule

bind uart_irq_timer uart_irq_timer_chk #(.PIN_N(PIN_N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .brk_set     (brk_set),
    .in_pins     (in_pins),
    .irq         (irq),
    .status      (status),
    .preset      (preset),
    .tmr_running (tmr_running),
    .pin_lvl     (pin_lvl),
    .pin_flags   (pin_flags)
);

// File: tb/test_uart_irq_timer.sv
`timescale 1ns/1ps
module test_uart_irq_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick = 1'b0;
    logic [1:0] tick_mult = '0;
    logic [1:0] tx_rdy = '0, rx_rdy = '0, brk_set = '0, brk_clr = '0;
    logic [3:0] in_pins = '0;
    logic       irq;

    typedef struct { logic [7:0] exp; string tag; } sb_item_t;
    sb_item_t sb[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_irq_timer i_uart_irq_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .tick_mult(tick_mult), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy),
        .brk_set(brk_set), .brk_clr(brk_clr), .in_pins(in_pins), .irq(irq)
    );

    // monitor: pops one expected item per read access
    always @(negedge clk) begin
        #1;
        if (bus_sel && !bus_wr) begin
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: read of %0d got %02h expected none", bus_addr, bus_rdata);
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                n_cmp++;
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        sb.push_back('{exp: e, tag: tag});
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rd_pins(input logic [3:0] a, input logic [7:0] e, input logic [3:0] p, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; in_pins = p;
        sb.push_back('{exp: e, tag: tag});
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
        end
    endtask

    task automatic brk(input logic [1:0] s, input logic [1:0] c);
        @(negedge clk); brk_set = s; brk_clr = c;
        @(negedge clk); brk_set = '0; brk_clr = '0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            if (sb.size() != 0) begin
                n_bad++;
                $display("FAIL scoreboard: %0d reads never observed, expected 0", sb.size());
            end
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk_irq(1'b0, "R11 irq after reset");
        rd(4'd5, 8'h00, "R11 status after reset");
        rd(4'd6, 8'h00, "R11 preset hi after reset");
        rd(4'd7, 8'h00, "R11 preset lo after reset");
        rd(4'd4, 8'h00, "R11 pin register after reset");

        // R5 preset bytes
        wr(4'd6, 8'h12); wr(4'd7, 8'h34);
        rd(4'd6, 8'h12, "R5 upper byte");
        rd(4'd7, 8'h34, "R5 lower byte");
        wr(4'd6, 8'hAB);
        rd(4'd7, 8'h34, "R5 lower byte kept");
        rd(4'd6, 8'hAB, "R5 upper byte replaced");

        // R3 / R2 / R1 levels and mask
        @(negedge clk); tx_rdy = 2'b01; rx_rdy = 2'b10;
        rd(4'd5, 8'h21, "R3 level bits tx A rx B");
        chk_irq(1'b0, "R1 irq with zero mask");
        wr(4'd5, 8'h20);
        chk_irq(1'b1, "R1 irq rx B masked in");
        wr(4'd5, 8'h02);
        chk_irq(1'b0, "R1 irq rx A only");
        rd(4'd5, 8'h21, "R2 offset 5 returns status not mask");
        @(negedge clk); tx_rdy = 2'b10; rx_rdy = 2'b01;
        rd(4'd5, 8'h12, "R3 level bits tx B rx A");
        chk_irq(1'b1, "R1 irq rx A now set");
        @(negedge clk); tx_rdy = '0; rx_rdy = '0;
        rd(4'd5, 8'h00, "R3 levels cleared");
        chk_irq(1'b0, "R1 irq drops with status");

        // R4 break bits
        brk(2'b01, 2'b00);
        rd(4'd5, 8'h04, "R4 break A set");
        brk(2'b10, 2'b01);
        rd(4'd5, 8'h40, "R4 break B set, A cleared");
        brk(2'b10, 2'b10);
        rd(4'd5, 8'h40, "R4 set wins over clear");
        brk(2'b00, 2'b10);
        rd(4'd5, 8'h00, "R4 break B cleared");

        // R6 countdown: preset 3, multiplier 2 -> 6 ticks
        wr(4'd6, 8'h00); wr(4'd7, 8'h03); tick_mult = 2'd1;
        rd(4'd14, 8'h00, "R6 start read returns zero");
        ticks(5);
        rd(4'd5, 8'h00, "R6 not ready after 5 of 6 ticks");
        ticks(1);
        rd(4'd5, 8'h08, "R6 ready after 6th tick");
        wr(4'd5, 8'h08);
        chk_irq(1'b1, "R1 counter ready interrupt");

        // R7 stop
        rd(4'd15, 8'h00, "R7 stop read returns zero");
        rd(4'd5, 8'h00, "R7 stop clears ready");
        chk_irq(1'b0, "R7 irq cleared by stop");
        wr(4'd7, 8'h02); tick_mult = 2'd0;
        rd(4'd14, 8'h00, "R7 start before cancel");
        ticks(1);
        rd(4'd15, 8'h00, "R7 cancel read");
        ticks(3);
        rd(4'd5, 8'h00, "R7 cancelled countdown never expires");

        // R8 restart
        rd(4'd14, 8'h00, "R8 first start");
        ticks(1);
        rd(4'd14, 8'h00, "R8 restart");
        ticks(1);
        rd(4'd5, 8'h00, "R8 restart reloads full count");
        ticks(1);
        rd(4'd5, 8'h08, "R8 ready after full count from restart");
        rd(4'd15, 8'h00, "R8 stop to clear");

        // R6 zero count
        wr(4'd7, 8'h00);
        rd(4'd14, 8'h00, "R6 zero-count start");
        rd(4'd5, 8'h08, "R6 zero count expires without ticks");
        rd(4'd15, 8'h00, "R6 stop after zero count");

        // R12 ignored writes, unused offset
        wr(4'd14, 8'hFF);
        rd(4'd5, 8'h00, "R12 write to start address starts nothing");
        rd(4'd9, 8'h00, "R12 unused offset reads zero");

        // R9 / R10 input change
        @(negedge clk); in_pins = 4'b0101;
        rd(4'd5, 8'h80, "R10 change sets status bit7");
        rd(4'd4, 8'h55, "R9 flags and levels");
        rd(4'd4, 8'h05, "R9 flags cleared by read");
        rd(4'd5, 8'h00, "R10 bit7 clear after read");
        rd_pins(4'd4, 8'h05, 4'b0100, "R9 read racing a change");
        rd(4'd4, 8'h14, "R9 change during read keeps flag");
        @(negedge clk); in_pins = 4'b0110;
        wr(4'd4, 8'h00);
        rd(4'd4, 8'h26, "R12 write to pin register ignored");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule